// File: doc/BRIEF.md
# Genlocked Video Frame Timing Generator

This block produces the timing skeleton of a small parallel video port in the pixel clock domain. It drives an active-high line sync that frames each row of pixel data and an active-high frame sync that frames a whole image. It also gives a pixel counter and a line counter that downstream logic uses to pick the value to put on the data bus. Horizontal and vertical blanking lengths are inputs. All outputs come from flops on the rising pixel clock edge, so a receiver samples them on that same edge.

Two synchronisation modes exist. As master the generator runs free. It drives the shared genlock pad with a short high pulse at the start of every frame and enables the pad driver. As slave it releases the pad, brings the external genlock level through a two-flop synchroniser and acts on rising edges only. Each edge starts one frame at the next line boundary. While it waits for an edge it keeps sending line sync pulses with frame sync low, so the sensor rows keep being clocked. An edge that arrives during a frame is held until that frame has finished all its lines.

Line slots run back to back. Each slot is a blank gap followed by the active pixels. The gap comes first, so frame sync can rise inside the gap of the first line, ahead of line sync. After the last line it stays high for one extra clock.

Top module: `vid_sync_gen`

## Requirements
- R1: Every line sync pulse is high for exactly ACT_PIX consecutive clocks (320 by default).
- R2: The low time between two line sync pulses in the same run of lines is max(hblank_len, 2) clocks; a new hblank_len value takes effect at the next line boundary.
- R3: Each frame sync high period contains exactly LINES line sync pulses (240 by default).
- R4: Frame sync rises exactly max(hblank_len, 2) clocks before the first line sync of the frame rises. It falls exactly one clock after the last line sync of the frame falls.
- R5: In slave mode (master_en = 0) a frame starts only after a rising edge on gl_in. Frame sync rises between 4 and (line period + 5) clocks after that edge when the generator is idle, and no frame starts without an edge.
- R6: In slave mode, between frames, line sync pulses with the normal width and gap keep coming while frame sync is low.
- R7: A slave genlock edge that arrives during a frame does not shorten it. The next frame starts within one line period after frame sync falls.
- R8: Only the rising edge of gl_in matters: a 1-clock high and a high lasting longer than a frame each start exactly one frame.
- R9: In master mode (master_en = 1) gl_oe is 1, and gl_out goes high in the same clock as frame sync rises and stays high for exactly GL_PULSE clocks (default 6) once per frame.
- R10: In master mode max(vblank_len, 1) line slots with no line sync separate frames. Frame sync rise-to-rise is (LINES + max(vblank_len,1)) x (max(hblank_len,2) + ACT_PIX) clocks, and line sync is never high while frame sync is low.
- R11: In slave mode gl_oe and gl_out are 0.
- R12: While rst_n is low, lsync, fsync, gl_out, gl_oe, pix_cnt and line_cnt are all 0.
- R13: While line sync is high, pix_cnt counts 0 to ACT_PIX-1 across the pulse, and line_cnt holds the 0-based index of the line within the frame. pix_cnt is 0 when line sync is low.
- R14: In master mode activity on gl_in has no effect on the timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| master_en | input | 1 | 1 selects master mode, 0 slave mode |
| hblank_len | input | BW | Requested gap between lines in clocks (minimum 2 applied) |
| vblank_len | input | BW | Blank line slots between frames in master mode (minimum 1 applied) |
| gl_in | input | 1 | Genlock pad input level |
| gl_out | output | 1 | Genlock pad output value |
| gl_oe | output | 1 | Genlock pad output enable |
| lsync | output | 1 | Line sync, active high |
| fsync | output | 1 | Frame sync, active high |
| pix_cnt | output | PXW | Pixel index within the active line |
| line_cnt | output | LNW | Line index within the frame |

## Verification
The properties assume that master_en stays constant outside reset, because a mode change in the middle of a slot could leave a dummy line sync pulse without frame sync. They also assume that hblank_len and vblank_len are held while a run is checked. The bench changes the mode and both blanking lengths only while reset is held, and it draws fresh random values for each run. Slave edges are spaced so that each lands either while the generator is idle or, in the one dedicated case, in the middle of a frame. No edge lands while another is still pending.

// File: rtl/vsg_pkg.sv
package vsg_pkg;

  // Kind of line slot the frame controller is currently in.
  typedef enum logic [1:0] {
    SLOT_WAIT  = 2'd0,  // between frames; dummy line pulses in slave mode
    SLOT_FRAME = 2'd1,  // active line of a frame
    SLOT_VBL   = 2'd2   // master vertical blank, no line pulse
  } slot_e;

  localparam int unsigned MIN_GAP = 2;

endpackage

// File: rtl/vsg_gl_sync.sv
module vsg_gl_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic rise_o
);

  logic meta_q, sync_q, hist_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
      hist_q <= 1'b0;
    end else begin
      meta_q <= pin_i;
      sync_q <= meta_q;
      hist_q <= sync_q;
    end
  end

  // only a low-to-high transition of the synchronised level counts
  assign rise_o = sync_q & ~hist_q;

endmodule

// File: rtl/vsg_line_timer.sv
module vsg_line_timer #(
  parameter int unsigned ACT_PIX = 320,
  parameter int unsigned BW      = 8,
  parameter int unsigned PXW     = 9,
  parameter int unsigned HW      = BW + PXW + 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [BW-1:0]  hblank_i,
  output logic           last_o,
  output logic           first_o,
  output logic           act_o,
  output logic [PXW-1:0] pix_o
);

  localparam logic [HW-1:0] ACT_M1 = HW'(ACT_PIX - 1);
  localparam logic [BW-1:0] GAP_MIN = BW'(vsg_pkg::MIN_GAP);

  logic [HW-1:0] h_q, h_d;
  logic [BW-1:0] gap_q, gap_d, gap_req;
  logic [HW-1:0] gap_w;

  assign gap_req = (hblank_i < GAP_MIN) ? GAP_MIN : hblank_i;
  assign gap_w   = HW'(gap_q);

  assign last_o  = (h_q == gap_w + ACT_M1);
  assign first_o = (h_q == '0);
  assign act_o   = (h_q >= gap_w);
  assign pix_o   = act_o ? PXW'(h_q - gap_w) : '0;

  always_comb begin
    h_d   = h_q + HW'(1);
    gap_d = gap_q;
    if (last_o) begin
      h_d   = '0;
      gap_d = gap_req;   // blank length is only taken at a slot boundary
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_q   <= '0;
      gap_q <= GAP_MIN;
    end else begin
      h_q   <= h_d;
      gap_q <= gap_d;
    end
  end

endmodule

// File: rtl/vsg_frame_fsm.sv
module vsg_frame_fsm
  import vsg_pkg::*;
#(
  parameter int unsigned LINES = 240,
  parameter int unsigned BW    = 8,
  parameter int unsigned LNW   = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           master_i,
  input  logic [BW-1:0]  vblank_i,
  input  logic           last_i,
  input  logic           rise_i,
  output slot_e          slot_o,
  output logic [LNW-1:0] line_o,
  output logic           tail_o
);

  localparam logic [LNW-1:0] LAST_LINE = LNW'(LINES - 1);

  slot_e          slot_q, slot_d;
  logic [LNW-1:0] line_q, line_d;
  logic [BW-1:0]  vb_q, vb_d;
  logic [BW-1:0]  vb_len;
  logic           pend_q, pend_d;
  logic           tail_q, tail_d;
  logic           start_slave;

  assign vb_len      = (vblank_i == '0) ? BW'(1) : vblank_i;
  assign start_slave = last_i && (slot_q == SLOT_WAIT) && !master_i && pend_q;

  // pending genlock edge: held across an active frame, consumed at start
  always_comb begin
    pend_d = pend_q;
    if (master_i)         pend_d = 1'b0;
    else if (start_slave) pend_d = rise_i;
    else if (rise_i)      pend_d = 1'b1;
  end

  always_comb begin
    slot_d = slot_q;
    line_d = line_q;
    vb_d   = vb_q;
    tail_d = tail_q;
    if (last_i) begin
      tail_d = (slot_q == SLOT_FRAME);
      unique case (slot_q)
        SLOT_WAIT: begin
          if (master_i || pend_q) begin
            slot_d = SLOT_FRAME;
            line_d = '0;
          end
        end
        SLOT_FRAME: begin
          if (line_q == LAST_LINE) begin
            line_d = '0;
            vb_d   = '0;
            slot_d = master_i ? SLOT_VBL : SLOT_WAIT;
          end else begin
            line_d = line_q + LNW'(1);
          end
        end
        SLOT_VBL: begin
          if (!master_i) begin
            slot_d = SLOT_WAIT;
          end else if (vb_q + BW'(1) >= vb_len) begin
            slot_d = SLOT_FRAME;
            line_d = '0;
          end else begin
            vb_d = vb_q + BW'(1);
          end
        end
        default: slot_d = SLOT_WAIT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q <= SLOT_WAIT;
      line_q <= '0;
      vb_q   <= '0;
      pend_q <= 1'b0;
      tail_q <= 1'b0;
    end else begin
      slot_q <= slot_d;
      line_q <= line_d;
      vb_q   <= vb_d;
      pend_q <= pend_d;
      tail_q <= tail_d;
    end
  end

  assign slot_o = slot_q;
  assign line_o = line_q;
  assign tail_o = tail_q;

endmodule

// File: rtl/vsg_gl_master.sv
module vsg_gl_master #(
  parameter int unsigned GL_PULSE = 6,
  parameter int unsigned CW       = $clog2(GL_PULSE + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic pulse_o
);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (start_i)           cnt_d = CW'(GL_PULSE);
    else if (cnt_q != '0)  cnt_d = cnt_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign pulse_o = (cnt_q != '0);

endmodule

// File: rtl/vid_sync_gen.sv
module vid_sync_gen
  import vsg_pkg::*;
#(
  parameter int unsigned ACT_PIX  = 320,
  parameter int unsigned LINES    = 240,
  parameter int unsigned BW       = 8,
  parameter int unsigned GL_PULSE = 6,
  localparam int unsigned PXW = (ACT_PIX > 1) ? $clog2(ACT_PIX) : 1,
  localparam int unsigned LNW = (LINES > 1) ? $clog2(LINES) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           master_en,
  input  logic [BW-1:0]  hblank_len,
  input  logic [BW-1:0]  vblank_len,
  input  logic           gl_in,
  output logic           gl_out,
  output logic           gl_oe,
  output logic           lsync,
  output logic           fsync,
  output logic [PXW-1:0] pix_cnt,
  output logic [LNW-1:0] line_cnt
);

  logic           slot_last, slot_first, slot_act;
  logic [PXW-1:0] slot_pix;
  logic           gl_rise;
  slot_e          slot;
  logic [LNW-1:0] frame_line;
  logic           after_frame;
  logic           gl_start, gl_pulse;

  vsg_gl_sync u_glsync (
    .clk    (clk),
    .rst_n  (rst_n),
    .pin_i  (gl_in),
    .rise_o (gl_rise)
  );

  vsg_line_timer #(
    .ACT_PIX (ACT_PIX),
    .BW      (BW),
    .PXW     (PXW)
  ) u_ltim (
    .clk      (clk),
    .rst_n    (rst_n),
    .hblank_i (hblank_len),
    .last_o   (slot_last),
    .first_o  (slot_first),
    .act_o    (slot_act),
    .pix_o    (slot_pix)
  );

  vsg_frame_fsm #(
    .LINES (LINES),
    .BW    (BW),
    .LNW   (LNW)
  ) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .master_i (master_en),
    .vblank_i (vblank_len),
    .last_i   (slot_last),
    .rise_i   (gl_rise),
    .slot_o   (slot),
    .line_o   (frame_line),
    .tail_o   (after_frame)
  );

  assign gl_start = master_en && (slot == SLOT_FRAME) && slot_first && (frame_line == '0);

  vsg_gl_master #(
    .GL_PULSE (GL_PULSE)
  ) u_glm (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (gl_start),
    .pulse_o (gl_pulse)
  );

  // output stage: every sync output leaves a flop
  logic           lsync_d, fsync_d;
  logic [PXW-1:0] pix_d;
  logic [LNW-1:0] line_d;
  logic           line_pulse_slot;

  assign line_pulse_slot = (slot == SLOT_FRAME) || ((slot == SLOT_WAIT) && !master_en);

  always_comb begin
    lsync_d = slot_act && line_pulse_slot;
    fsync_d = (slot == SLOT_FRAME) || (after_frame && slot_first);
    pix_d   = lsync_d ? slot_pix : '0;
    line_d  = (slot == SLOT_FRAME) ? frame_line : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lsync    <= 1'b0;
      fsync    <= 1'b0;
      pix_cnt  <= '0;
      line_cnt <= '0;
      gl_oe    <= 1'b0;
    end else begin
      lsync    <= lsync_d;
      fsync    <= fsync_d;
      pix_cnt  <= pix_d;
      line_cnt <= line_d;
      gl_oe    <= master_en;
    end
  end

  assign gl_out = gl_pulse && gl_oe;

endmodule

// File: rtl/vsg_sync_chk.sv
module vsg_sync_chk #(
  parameter int unsigned ACT_PIX = 320,
  parameter int unsigned LINES   = 240,
  parameter int unsigned PXW     = 9,
  parameter int unsigned LNW     = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic           lsync,
  input logic           fsync,
  input logic           gl_out,
  input logic           gl_oe,
  input logic [PXW-1:0] pix_cnt,
  input logic [LNW-1:0] line_cnt
);

  localparam int unsigned RW = $clog2(ACT_PIX + 2);

  logic [RW-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     run_q <= '0;
    else if (lsync) run_q <= run_q + RW'(1);
    else            run_q <= '0;
  end

  assert_lsync_width_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lsync) |-> (run_q == RW'(ACT_PIX)));

  assert_lsync_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= RW'(ACT_PIX));

  assert_fs_lead_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fsync) |-> !lsync);

  assert_fs_trail_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fsync) |-> (!lsync && !$past(lsync)));

  assert_master_inside_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (gl_oe && lsync) |-> fsync);

  assert_pad_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !gl_oe |-> !gl_out);

  assert_pix_idle_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !lsync |-> (pix_cnt == '0));

  assert_pix_step_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (lsync && $past(lsync)) |-> (pix_cnt == $past(pix_cnt) + PXW'(1)));

  assert_line_range_R13: assert property (@(posedge clk) disable iff (!rst_n)
    line_cnt < LNW'(LINES));

endmodule

bind vid_sync_gen vsg_sync_chk #(
  .ACT_PIX (ACT_PIX),
  .LINES   (LINES),
  .PXW     (PXW),
  .LNW     (LNW)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .lsync    (lsync),
  .fsync    (fsync),
  .gl_out   (gl_out),
  .gl_oe    (gl_oe),
  .pix_cnt  (pix_cnt),
  .line_cnt (line_cnt)
);

// File: tb/tb_vid_sync_gen.sv
`timescale 1ns/1ps
module tb_vid_sync_gen;

  localparam int ACT   = 12;
  localparam int LINES = 5;
  localparam int BW    = 6;
  localparam int PULSE = 6;
  localparam int PXW   = $clog2(ACT);
  localparam int LNW   = $clog2(LINES);

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           master_en = 1'b0;
  logic [BW-1:0]  hblank_len = '0;
  logic [BW-1:0]  vblank_len = '0;
  logic           gl_in = 1'b0;
  logic           gl_out, gl_oe, lsync, fsync;
  logic [PXW-1:0] pix_cnt;
  logic [LNW-1:0] line_cnt;

  vid_sync_gen #(
    .ACT_PIX (ACT), .LINES (LINES), .BW (BW), .GL_PULSE (PULSE)
  ) dut (
    .clk (clk), .rst_n (rst_n), .master_en (master_en),
    .hblank_len (hblank_len), .vblank_len (vblank_len),
    .gl_in (gl_in), .gl_out (gl_out), .gl_oe (gl_oe),
    .lsync (lsync), .fsync (fsync), .pix_cnt (pix_cnt), .line_cnt (line_cnt)
  );

  always #5 clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;
  int mst = 0;
  int geff = 2;
  int vbeff = 1;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int gap_of(input int hb);
    return (hb < 2) ? 2 : hb;
  endfunction

  function automatic int vbl_of(input int vb);
    return (vb < 1) ? 1 : vb;
  endfunction

  function automatic int period();
    return geff + ACT;
  endfunction

  // ---------------- monitor ----------------
  int cyc, run, gap, since_fs, pif, dmy, gl_run, frames, last_rise;
  bit prev_l, prev_f, prev_g, have_pulse;

  always @(negedge clk) begin
    if (!rst_n) begin
      cyc = 0; run = 0; gap = 0; since_fs = 0; pif = 0; dmy = 0;
      gl_run = 0; last_rise = -1;
      prev_l = 0; prev_f = 0; prev_g = 0; have_pulse = 0;
    end else begin
      cyc++;
      if (fsync && !prev_f) begin
        since_fs = 0;
        frames++;
        pif = 0;
        if (mst != 0) begin
          chk(gl_out && !prev_g, "R9 genlock pulse aligned with frame sync", int'(gl_out), 1);
          chk(gl_oe, "R9 pad enabled in master", int'(gl_oe), 1);
          chk(dmy == 0, "R10 no line sync outside frame", dmy, 0);
          if (last_rise >= 0)
            chk(cyc - last_rise == (LINES + vbeff) * period(),
                "R10 R14 master frame period", cyc - last_rise, (LINES + vbeff) * period());
        end else begin
          chk(!gl_out && !gl_oe, "R11 pad released in slave", int'(gl_oe), 0);
          if (last_rise >= 0) chk(dmy > 0, "R6 dummy lines between frames", dmy, 1);
        end
        dmy = 0;
        last_rise = cyc;
      end else begin
        since_fs++;
      end

      if (lsync) begin
        if (!prev_l) begin
          if (have_pulse && (mst == 0 || (fsync && pif > 0)))
            chk(gap == geff, (fsync ? "R2 line gap" : "R6 dummy line gap"), gap, geff);
          if (fsync) begin
            if (pif == 0) chk(since_fs == geff, "R4 leading porch", since_fs, geff);
            pif++;
            chk(int'(line_cnt) == pif - 1, "R13 line index", int'(line_cnt), pif - 1);
          end else begin
            dmy++;
          end
          run = 0;
        end
        chk(int'(pix_cnt) == run, "R13 pixel index", int'(pix_cnt), run);
        run++;
      end else begin
        if (prev_l) begin
          chk(run == ACT, "R1 line sync width", run, ACT);
          have_pulse = 1;
          gap = 1;
        end else begin
          gap++;
        end
      end

      if (!fsync && prev_f) begin
        chk(pif == LINES, "R3 lines per frame", pif, LINES);
        chk(gap == 2, "R4 trailing porch", gap, 2);
      end

      if (gl_out) gl_run++;
      else if (prev_g) begin
        chk(gl_run == PULSE, "R9 genlock pulse width", gl_run, PULSE);
        gl_run = 0;
      end

      prev_l = lsync; prev_f = fsync; prev_g = gl_out;
    end
  end

  // ---------------- watchdog ----------------
  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd >= 150000 && !done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog: actual %0d expected %0d", wd, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  task automatic start_run(input int m, input int hb, input int vb);
    rst_n = 1'b0;
    gl_in = 1'b0;
    mst = m;
    master_en = (m != 0);
    hblank_len = BW'(hb);
    vblank_len = BW'(vb);
    geff = gap_of(hb);
    vbeff = vbl_of(vb);
    frames = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // raise gl_in, hold it for hi clocks, and time the frame start
  task automatic slave_edge(input int hi, input bit timed);
    int n = 0;
    bit seen = 0;
    gl_in = 1'b1;
    while (!(seen && n >= hi) && n < 5000) begin
      @(negedge clk);
      n++;
      if (!seen && fsync) begin
        seen = 1;
        if (timed)
          chk(n >= 4 && n <= period() + 5, "R5 frame start latency", n, period() + 5);
      end
      if (n >= hi) gl_in = 1'b0;
    end
    gl_in = 1'b0;
    while (fsync) @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd4711));

    // reset state
    start_run(1, 3, 2);
    rst_n = 1'b0;
    @(negedge clk);
    chk(!lsync && !fsync && !gl_out && !gl_oe && pix_cnt == '0 && line_cnt == '0,
        "R12 reset outputs", int'({lsync, fsync, gl_out, gl_oe}), 0);
    idle(2);
    chk(!lsync && !fsync && !gl_oe, "R12 reset outputs held", int'({lsync, fsync, gl_oe}), 0);

    // master, random blanking, noise on the genlock pin
    start_run(1, $urandom_range(2, 6), $urandom_range(1, 3));
    for (int i = 0; i < 4 * (LINES + vbeff) * period() + 40; i++) begin
      @(negedge clk);
      if (i % 5 == 0) gl_in = $urandom_range(0, 1) != 0;
    end
    gl_in = 1'b0;
    chk(frames >= 4, "R10 R14 master frames produced", frames, 4);

    // master with blanking below the minimum
    start_run(1, 0, 0);
    idle(3 * (LINES + 1) * period() + 30);
    chk(frames >= 3, "R2 R10 clamped blanking frames", frames, 3);

    // slave: short, random and long genlock high times
    start_run(0, $urandom_range(2, 5), 0);
    idle(2 * period());
    for (int i = 0; i < 4; i++) begin
      int hi;
      case (i)
        0: hi = 1;
        1: hi = $urandom_range(2, 20);
        2: hi = 3 * LINES * period();
        default: hi = $urandom_range(1, 8);
      endcase
      slave_edge(hi, 1'b1);
      idle($urandom_range(period() + 3, 3 * period()));
    end
    chk(frames == 4, "R5 R8 one frame per rising edge", frames, 4);
    idle(4 * LINES * period());
    chk(frames == 4, "R5 no frame without an edge", frames, 4);

    // slave: second edge arrives in the middle of a frame
    start_run(0, 0, 0);
    idle(2 * period());
    gl_in = 1'b1;
    while (!fsync) @(negedge clk);
    idle(2);
    gl_in = 1'b0;
    idle(2 * period());
    gl_in = 1'b1;
    idle(3);
    gl_in = 1'b0;
    chk(fsync, "R7 first frame still running", int'(fsync), 1);
    while (fsync) @(negedge clk);
    begin
      int w = 0;
      while (!fsync && w < 1000) begin
        @(negedge clk);
        w++;
      end
      chk(w >= 1 && w <= period() + 4, "R7 held edge starts next frame", w, period() + 4);
    end
    while (fsync) @(negedge clk);
    idle(4);
    chk(frames == 2, "R7 both frames complete", frames, 2);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule